// File: doc/BRIEF.md
# Two-Wire Quad Wiper Register Controller

This block is the serial control front end of a four-channel digitally adjustable resistor. It sits on a two-wire open-drain bus as a target and samples SDA and SCL with a fast system clock. Its 7-bit target address is a fixed 5-bit prefix followed by two bits that must match two strap inputs. Over that bus a controller loads four 8-bit wiper registers, puts channels into shutdown or brings them out, drives two general-purpose logic outputs, and reads back one wiper register.

A write is an address byte with the direction bit low, an instruction byte and an optional data byte. The target acknowledges each of these bytes. The instruction byte, from MSB to LSB, is: channel select (2 bits), reset-to-midscale, shutdown, output 1, output 2, and two bits that are ignored. A read is an address byte with the direction bit high, followed by one byte that the target sends and that the controller does not acknowledge. The byte returned is the wiper register named by the most recent instruction.

The decoder is a single state machine with these states: ST_IDLE (waiting for a start), ST_ADDR (shifting in the address byte), ST_ADDR_ACK (acknowledge or release), ST_INSTR and ST_INSTR_ACK (instruction byte), ST_DATA and ST_DATA_ACK (data byte), ST_READ and ST_READ_ACK (sending the register and taking the controller's acknowledge bit), and ST_IGNORE (waiting for a stop). The transitions are as follows. A start moves any state to ST_ADDR, and a stop moves any state to ST_IDLE. In the receive states, the eighth falling SCL edge moves the machine to the matching acknowledge state. An address mismatch goes to ST_IGNORE instead. From ST_ADDR_ACK the machine goes to ST_READ or ST_INSTR according to the direction bit. ST_INSTR_ACK leads to ST_DATA. ST_DATA_ACK and ST_READ_ACK both lead to ST_IGNORE.

Top module: `i2c_quad_wiper_ctrl`

## Requirements
- R1: After reset every wiper register holds 0x80, every shutdown flag is 0, both logic outputs are 0, the read pointer is channel 0, and SDA is released.
- R2: The target acknowledges an address byte only if its bits 7..3 are 01011 and its bits 2..1 equal strap[1:0]. Any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R3: In a write, the address, instruction and data bytes are each acknowledged by pulling SDA low during the ninth SCL pulse. The data byte is stored in the wiper register chosen by instruction bits 7..6.
- R4: An instruction with bit 5 set loads 0x80 into the selected wiper register and leaves the other channels unchanged.
- R5: Instruction bit 4 is copied into the shutdown flag of the selected channel. Setting it leaves that wiper register unchanged. The flag clears only when an instruction to that channel carries bit 4 low.
- R6: Every accepted instruction latches bit 3 onto gpo_o[0] and bit 2 onto gpo_o[1].
- R7: In a read, the target acknowledges the address byte and then drives the selected register MSB first, one bit per SCL pulse. It then releases SDA for the controller's acknowledge bit.
- R8: A read returns the channel named by the most recent instruction byte, or channel 0 if no instruction has been received since reset.
- R9: If a stop follows the instruction byte, the reset, shutdown and output bits still take effect, but no wiper value is written.
- R10: A repeated start in the middle of a transaction returns the decoder to address reception.
- R11: Bytes after the data byte of a write are not acknowledged and change nothing.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap | input | 2 | Address strap pins compared with address bits 2..1 |
| wiper_o | output | NCH*DW | Wiper registers, channel c in bits c*DW+DW-1..c*DW |
| shdn_o | output | NCH | Per-channel shutdown flags |
| gpo_o | output | 2 | General-purpose logic outputs |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit registers and a two-flop synchronizer. With these values every strap setting can be swept against every address-pin combination, and every channel can be written and read back. The sweep covers matching and non-matching addresses, reset-to-midscale and shutdown on individual channels, all four output-pin patterns, an instruction with no data byte, a repeated start, and a trailing extra byte. A bus monitor also counts any change of the SDA drive while SCL is high.

// File: rtl/wiper_ctrl_pkg.sv
package wiper_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_IGNORE
    } tgt_state_t;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    // instruction byte field positions
    localparam int INS_SEL_HI = 7;
    localparam int INS_SEL_LO = 6;
    localparam int INS_RST    = 5;
    localparam int INS_SHDN   = 4;
    localparam int INS_OUT1   = 3;
    localparam int INS_OUT2   = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;
    logic scl_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = ~scl_q & scl_s;
    assign scl_fall  = scl_q & ~scl_s;
    assign start_det = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/wiper_i2c_fsm.sv
module wiper_i2c_fsm
    import wiper_ctrl_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              instr_we,
    output logic              data_we,
    output logic [BYTE_W-1:0] rx_byte
);
    tgt_state_t        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              byte_full;
    logic              addr_hit;
    logic              bus_evt;
    logic              rx_state;

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[7:3] == ADDR_PREFIX) && (shreg[2:1] == strap);
    assign bus_evt   = start_det | stop_det;
    assign rx_state  = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state <= ST_IDLE;
        else if (start_det)  state <= ST_ADDR;
        else if (stop_det)   state <= ST_IDLE;
        else                 state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_IDLE;
            ST_ADDR:      if (scl_fall && byte_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK:  if (scl_fall) nxt = shreg[0] ? ST_READ : ST_INSTR;
            ST_INSTR:     if (scl_fall && byte_full) nxt = ST_INSTR_ACK;
            ST_INSTR_ACK: if (scl_fall) nxt = ST_DATA;
            ST_DATA:      if (scl_fall && byte_full) nxt = ST_DATA_ACK;
            ST_DATA_ACK:  if (scl_fall) nxt = ST_IGNORE;
            ST_READ:      if (scl_fall && byte_full) nxt = ST_READ_ACK;
            ST_READ_ACK:  if (scl_fall) nxt = ST_IGNORE;
            ST_IGNORE:    nxt = ST_IGNORE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs: bit counter, shift registers, SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            sda_oe  <= 1'b0;
        end else if (bus_evt) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (scl_rise) begin
            if (rx_state || state == ST_READ) bit_cnt <= bit_cnt + 1'b1;
            if (rx_state) shreg <= {shreg[BYTE_W-2:0], sda_s};
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (byte_full) begin
                        bit_cnt <= '0;
                        sda_oe  <= (state != ST_ADDR) || addr_hit;
                    end
                end
                ST_ADDR_ACK: begin
                    sda_oe <= 1'b0;
                    if (shreg[0]) begin
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                    end
                end
                ST_READ: begin
                    if (byte_full) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end else begin
                        txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txreg[BYTE_W-2];
                    end
                end
                ST_INSTR_ACK, ST_DATA_ACK, ST_READ_ACK: sda_oe <= 1'b0;
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    assign instr_we = (state == ST_INSTR) && scl_fall && byte_full && !bus_evt;
    assign data_we  = (state == ST_DATA)  && scl_fall && byte_full && !bus_evt;
    assign rx_byte  = shreg;

endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
    import wiper_ctrl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [NCH-1:0]    shdn_o,
    output logic [1:0]        gpo_o,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [1:0] sel;
    logic [1:0] ins_sel;

    assign ins_sel = rx_byte[INS_SEL_HI:INS_SEL_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel   <= '0;
            gpo_o <= '0;
        end else if (instr_we) begin
            sel   <= ins_sel;
            gpo_o <= {rx_byte[INS_OUT2], rx_byte[INS_OUT1]};
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wiper_o[c*DW +: DW] <= MID;
                    shdn_o[c]           <= 1'b0;
                end else if (instr_we && ins_sel == 2'(c)) begin
                    if (rx_byte[INS_RST]) wiper_o[c*DW +: DW] <= MID;
                    shdn_o[c] <= rx_byte[INS_SHDN];
                end else if (data_we && sel == 2'(c)) begin
                    wiper_o[c*DW +: DW] <= DW'(rx_byte);
                end
            end
        end
    endgenerate

    assign rd_byte = BYTE_W'(wiper_o[sel*DW +: DW]);

endmodule

// File: rtl/i2c_quad_wiper_ctrl.sv
module i2c_quad_wiper_ctrl
    import wiper_ctrl_pkg::*;
#(
    parameter int         NCH         = 4,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [NCH-1:0]    shdn_o,
    output logic [1:0]        gpo_o
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              instr_we;
    logic              data_we;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] rd_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wiper_i2c_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .instr_we  (instr_we),
        .data_we   (data_we),
        .rx_byte   (rx_byte)
    );

    wiper_regfile #(.NCH(NCH), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_we (instr_we),
        .data_we  (data_we),
        .rx_byte  (rx_byte),
        .wiper_o  (wiper_o),
        .shdn_o   (shdn_o),
        .gpo_o    (gpo_o),
        .rd_byte  (rd_byte)
    );

endmodule

// File: rtl/wiper_ctrl_checker.sv
module wiper_ctrl_checker #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              instr_we,
    input logic              data_we,
    input logic [7:0]        rx_byte,
    input logic [NCH*DW-1:0] wiper_o,
    input logic [NCH-1:0]    shdn_o,
    input logic [1:0]        gpo_o
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    assert_wiper_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> $past(instr_we || data_we));

    assert_shdn_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shdn_o) |-> $past(instr_we));

    assert_gpo_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpo_o) |-> $past(instr_we));

    assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            assert_midscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_we && rx_byte[5] && rx_byte[7:6] == 2'(c)) |=> wiper_o[c*DW +: DW] == MID);
            assert_shdn_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_we && rx_byte[7:6] == 2'(c)) |=> shdn_o[c] == $past(rx_byte[4]));
        end
    endgenerate

endmodule

bind i2c_quad_wiper_ctrl wiper_ctrl_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .instr_we (instr_we),
    .data_we  (data_we),
    .rx_byte  (rx_byte),
    .wiper_o  (wiper_o),
    .shdn_o   (shdn_o),
    .gpo_o    (gpo_o)
);

// File: tb/test_i2c_quad_wiper_ctrl.sv
`timescale 1ns/1ps
module test_i2c_quad_wiper_ctrl;
    localparam int Q = 10;
    localparam logic [4:0] PFX = 5'b01011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b00;
    logic        sda_oe;
    logic [31:0] wiper_o;
    logic [3:0]  shdn_o;
    logic [1:0]  gpo_o;
    logic        sda_line;

    int n_checks = 0;
    int n_err = 0;
    int r12_viol = 0;
    bit done = 0;

    logic [7:0] exp_w [4];
    logic [3:0] exp_sd;
    logic [1:0] exp_gpo;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_quad_wiper_ctrl i_i2c_quad_wiper_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap   (strap),
        .wiper_o (wiper_o),
        .shdn_o  (shdn_o),
        .gpo_o   (gpo_o)
    );

    // R12 monitor: SDA drive must not change while SCL is high
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== prev_oe)) r12_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " wipers"}, wiper_o, {exp_w[3], exp_w[2], exp_w[1], exp_w[0]});
        check({tag, " shdn"}, {28'd0, shdn_o}, {28'd0, exp_sd});
        check({tag, " gpo"}, {30'd0, gpo_o}, {30'd0, exp_gpo});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        wq(Q);                       // controller leaves SDA released: no acknowledge
        scl_m = 1'b1; wq(Q);
        check("R7 SDA released in acknowledge slot", {31'd0, sda_line}, 32'd1);
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    function automatic logic [7:0] instr(input logic [1:0] ch, input logic rs, input logic sd,
                                         input logic o1, input logic o2);
        return {ch, rs, sd, o1, o2, 2'b00};
    endfunction

    task automatic model_instr(input logic [1:0] ch, input logic rs, input logic sd,
                               input logic o1, input logic o2);
        exp_gpo = {o2, o1};
        exp_sd[ch] = sd;
        if (rs) exp_w[ch] = 8'h80;
    endtask

    // full write: address, instruction, optional data, stop
    task automatic wr(input string tag, input logic [1:0] ch, input logic rs, input logic sd,
                      input logic o1, input logic o2, input bit with_data, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte({PFX, strap, 1'b0}, ack);
        check({tag, " R3 address ack"}, {31'd0, ack}, 32'd1);
        send_byte(instr(ch, rs, sd, o1, o2), ack);
        check({tag, " R3 instruction ack"}, {31'd0, ack}, 32'd1);
        model_instr(ch, rs, sd, o1, o2);
        if (with_data) begin
            send_byte(d, ack);
            check({tag, " R3 data ack"}, {31'd0, ack}, 32'd1);
            exp_w[ch] = d;
        end
        bus_stop();
    endtask

    task automatic rd(input string tag, input logic [7:0] exp);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({PFX, strap, 1'b1}, ack);
        check({tag, " R7 read address ack"}, {31'd0, ack}, 32'd1);
        recv_byte(b);
        bus_stop();
        check({tag, " R8 read value"}, {24'd0, b}, {24'd0, exp});
    endtask

    initial begin
        logic ack;
        for (int c = 0; c < 4; c++) exp_w[c] = 8'h80;
        exp_sd = '0;
        exp_gpo = '0;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R1 reset state
        check_state("R1 reset");
        check("R1 SDA released", {31'd0, sda_oe}, 32'd0);
        // R8 default read pointer is channel 0
        rd("R8 default", exp_w[0]);

        // R2 / R3 sweep: every strap against every address-pin pair
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                logic [7:0] val;
                strap = 2'(s);
                val = 8'(8'h13 + 37 * (4 * s + a));
                bus_start();
                send_byte({PFX, 2'(a), 1'b0}, ack);
                check("R2 address ack matches strap", {31'd0, ack}, {31'd0, (a == s)});
                send_byte(instr(2'(a), 1'b0, 1'b0, 1'b0, 1'b0), ack);
                if (a == s) begin
                    model_instr(2'(a), 1'b0, 1'b0, 1'b0, 1'b0);
                    send_byte(val, ack);
                    exp_w[a] = val;
                end
                bus_stop();
                check_state("R2 R3 sweep");
            end
        end
        strap = 2'b10;

        // wrong prefix is ignored
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, ack);
        check("R2 wrong prefix no ack", {31'd0, ack}, 32'd0);
        send_byte(instr(2'd0, 1'b1, 1'b1, 1'b1, 1'b1), ack);
        bus_stop();
        check_state("R2 wrong prefix no effect");

        // write and read back each channel (R3, R7, R8, R9 select without data)
        for (int c = 0; c < 4; c++) begin
            wr("R3 write", 2'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'(8'hA5 ^ (c * 8'h3C)));
            check_state("R3 write");
        end
        for (int c = 3; c >= 0; c--) begin
            wr("R9 select", 2'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
            check_state("R9 select no wiper write");
            rd("R8 channel", exp_w[c]);
        end

        // R4 reset to midscale
        wr("R4", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check_state("R4 midscale");
        check("R4 channel 2 value", {24'd0, wiper_o[23:16]}, 32'h80);

        // R5 shutdown set and clear
        wr("R5", 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check_state("R5 set ch1");
        wr("R5", 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check_state("R5 set ch3");
        check("R5 flags", {28'd0, shdn_o}, 32'ha);
        wr("R5", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6B);
        check_state("R5 clear ch1");

        // R6 output pin sweep
        for (int g = 0; g < 4; g++) begin
            wr("R6", 2'd0, 1'b0, 1'b0, g[0], g[1], 1'b0, 8'h00);
            check("R6 gpo", {30'd0, gpo_o}, 32'(g));
        end
        check_state("R6 after sweep");

        // R10 repeated start
        bus_start();
        send_byte({PFX, strap, 1'b0}, ack);
        send_byte(instr(2'd0, 1'b0, 1'b0, 1'b0, 1'b0), ack);
        model_instr(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        bus_start();
        send_byte({PFX, strap, 1'b0}, ack);
        check("R10 address ack after restart", {31'd0, ack}, 32'd1);
        send_byte(instr(2'd1, 1'b0, 1'b0, 1'b1, 1'b0), ack);
        model_instr(2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        send_byte(8'h5A, ack);
        exp_w[1] = 8'h5A;
        bus_stop();
        check_state("R10 restart write");

        // R11 extra byte
        bus_start();
        send_byte({PFX, strap, 1'b0}, ack);
        send_byte(instr(2'd3, 1'b0, 1'b0, 1'b0, 1'b0), ack);
        model_instr(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send_byte(8'h33, ack);
        exp_w[3] = 8'h33;
        send_byte(8'h77, ack);
        check("R11 extra byte no ack", {31'd0, ack}, 32'd0);
        bus_stop();
        check_state("R11 extra byte ignored");
        rd("R11 readback", 8'h33);

        check("R12 SDA drive changes while SCL high", 32'(r12_viol), 32'd0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule